// File: doc/BRIEF.md
# Scanline-Stepped Interrupt Timer

This block is a cartridge-side interrupt timer. The CPU loads a 16-bit count one byte at a time and writes a control byte. While counting is switched on, every scanline pulse takes a fixed step of 113 off the count. When a pulse finds 113 or fewer counts left, the count drops to zero and an interrupt request goes high.

The request is a level. It stays high through later pulses and through any other CPU writes. Only a write to the control register or a reset clears it, so writing the control byte also serves as the acknowledge. The block decodes its three write addresses itself. A CPU write to any of them in the same clock as a scanline pulse takes priority, and that pulse is dropped.

Top module: `scanline_irq_timer`

## Requirements
- R1: After reset the request is low, the count is 0 and the control byte is 0. The first pulse after counting is switched on therefore raises the request.
- R2: A write to address 0xF000 replaces count bits 7:0 and leaves bits 15:8 unchanged.
- R3: A write to address 0xF004 replaces count bits 15:8 and leaves bits 7:0 unchanged.
- R4: A write to address 0xF008 stores the full data byte as the control byte and drives the request low in the next cycle.
- R5: Counting is on only while control bit 1 is 1. The other control bits have no effect on counting.
- R6: A scanline pulse while counting, with a count of 113 or less, sets the count to 0 and raises the request in the next cycle.
- R7: A scanline pulse while counting, with a count above 113, lowers the count by exactly 113 and leaves the request unchanged.
- R8: Once high, the request stays high until a write to 0xF008 or a reset, including across further pulses at count 0.
- R9: A CPU write to 0xF000, 0xF004 or 0xF008 in the same clock as a pulse takes effect, and that pulse is ignored.
- R10: While counting is off, pulses leave the count unchanged and do not raise the request.
- R11: Writes to any other address change neither the count, the control byte nor the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| line_tick | input | 1 | One-cycle scanline pulse |
| irq | output | 1 | Interrupt request, active high level |

## Verification
The assertions assume that the write strobe and the scanline pulse are sampled once per clock. They also assume the address is stable whenever the strobe is high, so that each write hits exactly one register. The stimulus drives all inputs at the falling edge and holds them for a whole cycle. It deliberately overlaps pulses with writes to exercise the priority rule, and it keeps loaded counts small enough that firing is reached within a bounded number of pulses.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

  // Kind of CPU access seen by the timer in one clock
  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_COUNT = 2'd1,
    WK_CTRL  = 2'd2,
    WK_OTHER = 2'd3
  } wr_kind_e;

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned BASE   = 'hF000,
  parameter int unsigned STRIDE = 4
) (
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [LANES-1:0]  lane_we,
  output logic              ctrl_we,
  output wr_kind_e          kind
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BASE + LANES * STRIDE);

  // one byte lane of the count per address step
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE + g * STRIDE);
    assign lane_we[g] = cpu_wr && (cpu_addr == LANE_ADDR);
  end

  assign ctrl_we = cpu_wr && (cpu_addr == CTRL_ADDR);

  always_comb begin
    if (!cpu_wr)        kind = WK_NONE;
    else if (|lane_we)  kind = WK_COUNT;
    else if (ctrl_we)   kind = WK_CTRL;
    else                kind = WK_OTHER;
  end

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STEP   = 113,
  parameter int unsigned EN_BIT = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CNT_W/DATA_W-1:0]     lane_we,
  input  logic                        ctrl_we,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        line_tick,
  output logic [CNT_W-1:0]            cnt,
  output logic [DATA_W-1:0]           ctrl,
  output logic                        step_go,
  output logic                        step_fire
);

  localparam int unsigned LANES = CNT_W / DATA_W;
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  // true when the remaining count cannot absorb another full step
  function automatic logic at_floor(input logic [CNT_W-1:0] v);
    return v <= STEP_V;
  endfunction

  // value after one step, clamped at zero
  function automatic logic [CNT_W-1:0] stepped(input logic [CNT_W-1:0] v);
    return at_floor(v) ? '0 : v - STEP_V;
  endfunction

  logic             cpu_hit;
  logic [CNT_W-1:0] base_next;
  logic [CNT_W-1:0] cnt_next;

  assign cpu_hit   = (|lane_we) || ctrl_we;
  assign step_go   = line_tick && ctrl[EN_BIT] && !cpu_hit;
  assign step_fire = step_go && at_floor(cnt);
  assign base_next = step_go ? stepped(cnt) : cnt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cnt_next[g*DATA_W +: DATA_W] =
      lane_we[g] ? wr_data : base_next[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      ctrl <= '0;
    end else begin
      cnt <= cnt_next;
      if (ctrl_we) ctrl <= wr_data;
    end
  end

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic req
);

  always_ff @(posedge clk) begin
    if (!rst_n)       req <= 1'b0;
    else if (clr_req) req <= 1'b0;
    else if (set_req) req <= 1'b1;
  end

endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
  import irq_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned STEP   = 113,
  parameter int unsigned BASE   = 'hF000,
  parameter int unsigned STRIDE = 4,
  parameter int unsigned EN_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_wr,
  input  logic              line_tick,
  output logic              irq
);

  localparam int unsigned LANES = CNT_W / DATA_W;

  logic [LANES-1:0]  lane_we;
  logic              ctrl_we;
  wr_kind_e          wr_kind;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] ctrl;
  logic              step_go;
  logic              step_fire;

  irq_wr_decode #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .BASE   (BASE),
    .STRIDE (STRIDE)
  ) u_dec (
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .lane_we  (lane_we),
    .ctrl_we  (ctrl_we),
    .kind     (wr_kind)
  );

  irq_line_counter #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .STEP   (STEP),
    .EN_BIT (EN_BIT)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_we   (lane_we),
    .ctrl_we   (ctrl_we),
    .wr_data   (cpu_data),
    .line_tick (line_tick),
    .cnt       (cnt),
    .ctrl      (ctrl),
    .step_go   (step_go),
    .step_fire (step_fire)
  );

  irq_req_latch u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (step_fire),
    .clr_req (ctrl_we),
    .req     (irq)
  );

endmodule

// File: rtl/irq_timer_chk.sv
module irq_timer_chk
  import irq_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned STEP   = 113,
  parameter int unsigned EN_BIT = 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CNT_W/DATA_W-1:0] lane_we,
  input logic                    ctrl_we,
  input wr_kind_e                wr_kind,
  input logic [DATA_W-1:0]       wr_data,
  input logic                    line_tick,
  input logic [CNT_W-1:0]        cnt,
  input logic [DATA_W-1:0]       ctrl,
  input logic                    step_go,
  input logic                    step_fire,
  input logic                    irq
);

  localparam int unsigned LANES = CNT_W / DATA_W;
  localparam int unsigned HI_LO = CNT_W - DATA_W;

  AST_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we[0] |=> (cnt[DATA_W-1:0] == $past(wr_data)) && (cnt[CNT_W-1:DATA_W] == $past(cnt[CNT_W-1:DATA_W]))); // R2

  AST_HIGH_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we[LANES-1] |=> (cnt[CNT_W-1:HI_LO] == $past(wr_data)) && (cnt[HI_LO-1:0] == $past(cnt[HI_LO-1:0]))); // R3

  AST_CTRL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !irq && (ctrl == $past(wr_data))); // R4

  AST_FIRE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && ctrl[EN_BIT] && wr_kind != WK_COUNT && wr_kind != WK_CTRL && cnt <= STEP) |=> (cnt == '0) && irq); // R6

  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(step_fire)); // R6

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && ctrl[EN_BIT] && wr_kind != WK_COUNT && wr_kind != WK_CTRL && cnt > STEP) |=> (cnt == $past(cnt) - STEP) && (irq == $past(irq))); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_we) |=> irq); // R8

  AST_CPU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == WK_COUNT || wr_kind == WK_CTRL) |-> !step_go); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[EN_BIT] && lane_we == '0) |=> $stable(cnt)); // R10

  AST_FOREIGN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == WK_OTHER && !line_tick) |=> $stable(cnt) && $stable(ctrl) && $stable(irq)); // R11

endmodule

bind scanline_irq_timer irq_timer_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .STEP   (STEP),
  .EN_BIT (EN_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lane_we   (lane_we),
  .ctrl_we   (ctrl_we),
  .wr_kind   (wr_kind),
  .wr_data   (cpu_data),
  .line_tick (line_tick),
  .cnt       (cnt),
  .ctrl      (ctrl),
  .step_go   (step_go),
  .step_fire (step_fire),
  .irq       (irq)
);

// File: tb/sim_scanline_irq_timer.sv
`timescale 1ns/1ps
module sim_scanline_irq_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic        line_tick = 1'b0;
  logic        irq;

  always #10 clk = ~clk;   // 50 MHz

  scanline_irq_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_data  (cpu_data),
    .cpu_wr    (cpu_wr),
    .line_tick (line_tick),
    .irq       (irq)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // behavioural reference: plain integers
  int m_cnt = 0;
  int m_ctl = 0;
  int m_irq = 0;
  bit m_took;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ctl = 0; m_irq = 0;
    end else begin
      m_took = 0;
      if (cpu_wr) begin
        if (cpu_addr == 16'hF000) begin m_cnt = (m_cnt / 256) * 256 + cpu_data; m_took = 1; end
        if (cpu_addr == 16'hF004) begin m_cnt = (m_cnt % 256) + cpu_data * 256; m_took = 1; end
        if (cpu_addr == 16'hF008) begin m_ctl = cpu_data; m_irq = 0; m_took = 1; end
      end
      if (!m_took && line_tick && ((m_ctl / 2) % 2 == 1)) begin
        if (m_cnt <= 113) begin m_cnt = 0; m_irq = 1; end
        else m_cnt = m_cnt - 113;
      end
    end
  end

  task automatic cmp_model();
    n_vec++;
    if (irq !== (m_irq != 0)) begin
      n_bad++;
      $display("FAIL %s model: irq=%0b expected %0b at %0t", cur_req, irq, (m_irq != 0), $time);
    end
  endtask

  task automatic expect_irq(input logic e, input string req);
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq=%0b expected %0b at %0t", req, irq, e, $time);
    end
  endtask

  task automatic cyc(input logic w, input logic [15:0] a, input logic [7:0] d, input logic t);
    cpu_wr = w; cpu_addr = a; cpu_data = d; line_tick = t;
    @(negedge clk);
    cmp_model();
    cpu_wr = 1'b0; line_tick = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic tick();
    cyc(1'b0, 16'h0000, 8'h00, 1'b1);
  endtask

  task automatic load(input int v);
    wr(16'hF000, 8'(v % 256));
    wr(16'hF004, 8'(v / 256));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_irq(1'b0, "R1");

    // R1: zero count after reset fires on first enabled pulse
    cur_req = "R1";
    wr(16'hF008, 8'h02);
    tick(); expect_irq(1'b1, "R1");
    cur_req = "R8";
    tick(); expect_irq(1'b1, "R8");
    cur_req = "R11";
    wr(16'hF00C, 8'h02); expect_irq(1'b1, "R11");
    cur_req = "R4";
    wr(16'hF008, 8'h02); expect_irq(1'b0, "R4");

    // R7 / R6: 300 -> 187 -> 74 -> fire
    cur_req = "R7";
    load(300);
    tick(); expect_irq(1'b0, "R7");
    tick(); expect_irq(1'b0, "R7");
    cur_req = "R6";
    tick(); expect_irq(1'b1, "R6");
    tick(); expect_irq(1'b1, "R8");

    // boundary: exactly 113 fires
    wr(16'hF008, 8'h02); load(113);
    tick(); expect_irq(1'b1, "R6");
    // boundary: 114 steps to 1 then fires
    wr(16'hF008, 8'h02); load(114);
    tick(); expect_irq(1'b0, "R7");
    tick(); expect_irq(1'b1, "R6");

    // R3: high write keeps low byte (0x72 survives)
    cur_req = "R3";
    wr(16'hF008, 8'h02); load(114);
    wr(16'hF004, 8'h01); wr(16'hF004, 8'h00);
    tick(); expect_irq(1'b0, "R3");
    tick(); expect_irq(1'b1, "R3");

    // R2: low write keeps high byte -> 0x01FF = 511 needs 5 pulses
    cur_req = "R2";
    wr(16'hF008, 8'h02); load(256);
    wr(16'hF000, 8'hFF);
    for (int i = 0; i < 4; i++) begin tick(); expect_irq(1'b0, "R2"); end
    tick(); expect_irq(1'b1, "R2");

    // R10 / R5: disabled pulses keep count, other control bits irrelevant
    cur_req = "R10";
    wr(16'hF008, 8'hFD); expect_irq(1'b0, "R4");
    load(200);
    for (int i = 0; i < 3; i++) begin tick(); expect_irq(1'b0, "R10"); end
    cur_req = "R5";
    wr(16'hF008, 8'hF2);
    tick(); expect_irq(1'b0, "R5");
    tick(); expect_irq(1'b1, "R5");

    // R9: count write wins over a pulse in the same clock
    cur_req = "R9";
    wr(16'hF008, 8'h02); load(0);
    cyc(1'b1, 16'hF000, 8'hC8, 1'b1); expect_irq(1'b0, "R9");
    tick(); expect_irq(1'b0, "R9");
    tick(); expect_irq(1'b1, "R9");
    // control write with pulse: acknowledge wins, pulse dropped
    load(0);
    cyc(1'b1, 16'hF008, 8'h02, 1'b1); expect_irq(1'b0, "R9");
    tick(); expect_irq(1'b1, "R9");

    // R11: foreign addresses touch nothing
    cur_req = "R11";
    wr(16'hF008, 8'h02); load(200);
    wr(16'hF001, 8'h00); wr(16'h8800, 8'h00); wr(16'hF00C, 8'hFF);
    tick(); expect_irq(1'b0, "R11");
    tick(); expect_irq(1'b1, "R11");
    wr(16'hF009, 8'h02); expect_irq(1'b1, "R11");

    // mixed stream against the reference model
    cur_req = "R6_R7_R9_mix";
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [15:0] a;
      logic [7:0]  d;
      sel = $urandom_range(0, 9);
      d   = 8'($urandom);
      case (sel)
        0: a = 16'hF000;
        1: begin a = 16'hF004; d = 8'($urandom_range(0, 3)); end
        2: begin a = 16'hF008; d = {d[7:2], 1'b1, d[0]}; end
        3: a = 16'hF008;
        4: a = 16'hF00C;
        default: a = 16'h9000;
      endcase
      cyc(($urandom_range(0, 3) == 0), a, d, ($urandom_range(0, 1) == 1));
    end

    finish_run();
  end

endmodule